// File: doc/BRIEF.md
# Four-Channel Prioritized DMA Engine

This block moves data between addresses on a simple single-master memory bus for four independent channels. Each channel is loaded through a configuration strobe with a source address, a destination address, a unit count, a unit size (8, 16 or 32 bits) and a mode flag that selects block or single-step operation. Every unit moves in two bus cycles. A read cycle at the source captures the data into an internal holding register. A forced idle gap of one or two clocks follows. A write cycle then sends the held data to the destination.

A fixed-priority arbiter chooses among the channels whose request input is high and that are still enabled. In single-step mode a channel gives up the bus after each unit, so a more urgent request can take over at that boundary. In block mode the granted channel keeps the bus until its count is used up. Loads that break the address rules are refused, and the channel's error flag is raised. The rules are a reserved aliased page, block mode toward the peripheral register page, and a size that does not match the width of the peripheral register. A channel that finishes its count raises its done flag and turns itself off.

Top module: `dma4_engine`

## Requirements
- R1: Each unit is a read cycle (bus_we=0) at the channel's current source address, followed later by a write cycle (bus_we=1) at its current destination address. The write data is the read data with the bits above the unit size forced to zero. Data sits in the low bits of the bus.
- R2: Between the read cycle's acknowledge and the write cycle, bus_valid stays low for exactly 1 clock when gap_two=0 and exactly 2 clocks when gap_two=1.
- R3: At each arbitration point, the lowest-numbered channel that has dma_req high and is enabled wins.
- R4: A block-mode channel (cfg_block=1) keeps the bus from its grant until its count reaches zero. Other requests, and the fall of its own request, have no effect until then.
- R5: A single-step channel (cfg_block=0) moves one unit per grant. A higher-priority request that is present when that unit ends is served before the channel's next unit.
- R6: A load with cfg_block=1 is refused when either address lies in the peripheral page (address bits [27:12] equal 16'hFFFF). The channel's err bit is set and the channel stays disabled, so it makes no bus cycles.
- R7: When an endpoint lies in the peripheral page, the size must equal that register's width. Address bits [11:10]=00 mean byte, 01 mean halfword, and 10 or 11 mean word. A load with any other size is refused with err set. A matching load is accepted with err clear.
- R8: A load with either address in the reserved aliased page (address bits [27:12] equal 16'h3FFF) is refused with err set.
- R9: Size codes are 0=byte, 1=halfword, 2=word, and code 3 is refused, as is a count of zero. After each unit, both addresses advance by the size in bytes and the count drops by one. When the count reaches zero, done is set and the channel is disabled, so it makes no further bus cycles.
- R10: After reset, bus_valid, done and err are all zero and no channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gap_two | input | 1 | Idle gap between read and write: 0 gives one clock, 1 gives two |
| cfg_we | input | 4 | One-hot load strobe, one bit per channel |
| cfg_src | input | 28 | Source address to load |
| cfg_dst | input | 28 | Destination address to load |
| cfg_count | input | 16 | Number of units to load |
| cfg_size | input | 2 | Unit size code to load |
| cfg_block | input | 1 | 1 selects block mode, 0 selects single-step |
| dma_req | input | 4 | Level-sensitive transfer requests |
| done | output | 4 | Per-channel completion flags |
| err | output | 4 | Per-channel refused-load flags |
| bus_valid | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 28 | Byte address of the cycle |
| bus_size | output | 2 | Size code of the cycle |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_ack | input | 1 | Cycle completes at the clock edge where this is high |

## Verification
The hardest situation to reach is a request that changes exactly at a unit boundary. Single-step preemption, and the refusal to preempt in block mode, both show only when the higher-priority request rises after the current channel's first write has begun and before the next arbitration. The stimulus watches the bus for the first write cycle of the running channel and raises the urgent request on that same cycle. The scoreboard holds the interleaved order of reads and writes and the idle-gap length that must follow. Refused loads are checked by holding the request high for a window and confirming that no bus cycle appears.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
package dma4_pkg;
    localparam int ADDR_W   = 28;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 16;
    localparam int PAGE_LSB = 12;
    localparam logic [ADDR_W-PAGE_LSB-1:0] PERI_PAGE = 16'hFFFF;
    localparam logic [ADDR_W-PAGE_LSB-1:0] RSVD_PAGE = 16'h3FFF;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xsize_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        xsize_e            size;
        logic              blk;
        logic              en;
        logic              done;
        logic              err;
    } chan_t;

    function automatic logic in_peri(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:PAGE_LSB] == PERI_PAGE;
    endfunction

    function automatic logic in_rsvd(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:PAGE_LSB] == RSVD_PAGE;
    endfunction

    function automatic xsize_e peri_width(input logic [ADDR_W-1:0] a);
        case (a[11:10])
            2'b00:   return SZ_BYTE;
            2'b01:   return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] size_bytes(input xsize_e s);
        return ADDR_W'(1) << s;
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input xsize_e s);
        case (s)
            SZ_BYTE: return DATA_W'(32'h0000_00FF);
            SZ_HALF: return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

    function automatic logic load_ok(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d,
                                     input logic [CNT_W-1:0] n, input xsize_e z, input logic b);
        logic ok;
        ok = (z != SZ_BAD) && (n != '0);
        if (in_rsvd(s) || in_rsvd(d))            ok = 1'b0;
        if (b && (in_peri(s) || in_peri(d)))     ok = 1'b0;
        if (in_peri(s) && z != peri_width(s))    ok = 1'b0;
        if (in_peri(d) && z != peri_width(d))    ok = 1'b0;
        return ok;
    endfunction
endpackage

// File: rtl/dma4_prio_arb.sv
`timescale 1ns/1ps
module dma4_prio_arb #(
    parameter int NCH = 4,
    localparam int IW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NCH-1:0] elig,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    always_comb begin
        gnt_valid = |elig;
        gnt_idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) gnt_idx = IW'(i);
        end
    end

    // R3: the chosen channel is eligible and nothing below it is
    p_lowest_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (elig[gnt_idx] && ((elig & ((NCH'(1) << gnt_idx) - NCH'(1))) == '0)));
endmodule

// File: rtl/dma4_xfer_seq.sv
`timescale 1ns/1ps
module dma4_xfer_seq
    import dma4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gap_two,
    input  logic              go,
    input  logic              stay,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  xsize_e            size,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              unit_done,
    output logic              idle
);
    typedef enum logic [1:0] {S_IDLE, S_READ, S_GAP, S_WRITE} st_e;
    typedef struct packed {
        st_e               st;
        logic              gcnt;
        logic [DATA_W-1:0] hold;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            S_IDLE:  if (go) seq_d.st = S_READ;
            S_READ:  if (bus_ack) begin
                seq_d.hold = bus_rdata & size_mask(size);
                seq_d.gcnt = gap_two;
                seq_d.st   = S_GAP;
            end
            S_GAP:   if (seq_q.gcnt) seq_d.gcnt = 1'b0;
                     else            seq_d.st   = S_WRITE;
            S_WRITE: if (bus_ack) seq_d.st = stay ? S_READ : S_IDLE;
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_IDLE, gcnt: 1'b0, hold: '0};
        else        seq_q <= seq_d;
    end

    assign bus_valid = (seq_q.st == S_READ) || (seq_q.st == S_WRITE);
    assign bus_we    = (seq_q.st == S_WRITE);
    assign bus_addr  = (seq_q.st == S_WRITE) ? dst : src;
    assign bus_size  = size;
    assign bus_wdata = seq_q.hold;
    assign unit_done = (seq_q.st == S_WRITE) && bus_ack;
    assign idle      = (seq_q.st == S_IDLE);

    // R2: a write cycle is only ever entered from the idle gap
    p_gap_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_WRITE && $past(seq_q.st) != S_WRITE) |-> $past(seq_q.st) == S_GAP);
    // R2: a two-clock gap does not leave after its first clock
    p_gap_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_GAP && $past(seq_q.st) == S_READ && $past(gap_two)) |=> seq_q.st == S_GAP);
endmodule

// File: rtl/dma4_engine.sv
`timescale 1ns/1ps
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    localparam int IW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gap_two,
    input  logic [NCH-1:0]    cfg_we,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_block,
    input  logic [NCH-1:0]    dma_req,
    output logic [NCH-1:0]    done,
    output logic [NCH-1:0]    err,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    typedef struct packed {
        chan_t [NCH-1:0] ch;
        logic [IW-1:0]   cur;
    } eng_t;

    eng_t           eng_q, eng_d;
    logic [NCH-1:0] en_vec;
    logic           gnt_valid, go, stay, seq_idle, unit_done;
    logic [IW-1:0]  gnt_idx;
    chan_t          cur_ch;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            en_vec[i] = eng_q.ch[i].en;
            done[i]   = eng_q.ch[i].done;
            err[i]    = eng_q.ch[i].err;
        end
    end

    assign cur_ch = eng_q.ch[eng_q.cur];
    assign go     = seq_idle && gnt_valid;
    assign stay   = cur_ch.blk && (cur_ch.cnt != CNT_W'(1));

    dma4_prio_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (dma_req & en_vec),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    dma4_xfer_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .gap_two   (gap_two),
        .go        (go),
        .stay      (stay),
        .src       (cur_ch.src),
        .dst       (cur_ch.dst),
        .size      (cur_ch.size),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .unit_done (unit_done),
        .idle      (seq_idle)
    );

    always_comb begin
        eng_d = eng_q;
        if (go) eng_d.cur = gnt_idx;
        if (unit_done) begin
            eng_d.ch[eng_q.cur].src = cur_ch.src + size_bytes(cur_ch.size);
            eng_d.ch[eng_q.cur].dst = cur_ch.dst + size_bytes(cur_ch.size);
            eng_d.ch[eng_q.cur].cnt = cur_ch.cnt - CNT_W'(1);
            if (cur_ch.cnt == CNT_W'(1)) begin
                eng_d.ch[eng_q.cur].en   = 1'b0;
                eng_d.ch[eng_q.cur].done = 1'b1;
            end
        end
        for (int i = 0; i < NCH; i++) begin
            if (cfg_we[i]) begin
                eng_d.ch[i].src  = cfg_src;
                eng_d.ch[i].dst  = cfg_dst;
                eng_d.ch[i].cnt  = cfg_count;
                eng_d.ch[i].size = xsize_e'(cfg_size);
                eng_d.ch[i].blk  = cfg_block;
                eng_d.ch[i].done = 1'b0;
                eng_d.ch[i].en   = load_ok(cfg_src, cfg_dst, cfg_count, xsize_e'(cfg_size), cfg_block);
                eng_d.ch[i].err  = !eng_d.ch[i].en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    // R4: a block channel with units left goes straight back to reading, same channel
    p_block_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && stay) |=> (!seq_idle && $stable(eng_q.cur)));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R9: completion always turns the channel off
        p_done_disables_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done[g]) |-> !en_vec[g]);
        // R6: block mode toward the peripheral page is refused
        p_reject_peri_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we[g] && cfg_block && (in_peri(cfg_src) || in_peri(cfg_dst))) |=> (err[g] && !en_vec[g]));
        // R8: the reserved aliased page is refused
        p_reject_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we[g] && (in_rsvd(cfg_src) || in_rsvd(cfg_dst))) |=> (err[g] && !en_vec[g]));
    end
endmodule

// File: tb/dma4_engine_bench.sv
`timescale 1ns/1ps
module dma4_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gap_two = 1'b0;
    logic [3:0]  cfg_we = '0;
    logic [27:0] cfg_src = '0, cfg_dst = '0;
    logic [15:0] cfg_count = '0;
    logic [1:0]  cfg_size = '0;
    logic        cfg_block = 1'b0;
    logic [3:0]  dma_req = '0;
    logic [3:0]  done, err;
    logic        bus_valid, bus_we, bus_ack;
    logic [27:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    dma4_engine u_dma4_engine (
        .clk(clk), .rst_n(rst_n), .gap_two(gap_two), .cfg_we(cfg_we),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .cfg_size(cfg_size), .cfg_block(cfg_block), .dma_req(dma_req),
        .done(done), .err(err), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // bus model: zero-wait acknowledge, contents derived from the address
    function automatic logic [31:0] model_rd(input logic [27:0] a);
        logic [31:0] v;
        for (int b = 0; b < 4; b++) begin
            logic [27:0] ab;
            ab = a + 28'(b);
            v[b*8 +: 8] = ab[7:0] ^ 8'h5A;
        end
        return v;
    endfunction

    function automatic logic [31:0] mask_of(input logic [1:0] s);
        return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    assign bus_ack   = bus_valid;
    assign bus_rdata = model_rd(bus_addr);

    typedef struct {
        logic        we;
        logic [27:0] addr;
        logic [1:0]  sz;
        logic [31:0] data;
        int          gap;
        string       tag;
    } op_t;

    op_t expq[$];
    int  total = 0, bad = 0, ops = 0, idle_run = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_valid) begin
                ops++;
                if (expq.size() == 0) begin
                    chk(0, "R9 unexpected bus cycle", 32'(bus_addr), 32'hFFFF_FFFF);
                end else begin
                    op_t e;
                    e = expq.pop_front();
                    chk(bus_we == e.we && bus_addr == e.addr && bus_size == e.sz,
                        {e.tag, " cycle kind/address/size"},
                        {bus_we, 1'b0, bus_size, bus_addr}, {e.we, 1'b0, e.sz, e.addr});
                    if (e.we) begin
                        chk(bus_wdata == e.data, {e.tag, " write data"}, bus_wdata, e.data);
                        chk(idle_run == e.gap, "R2 idle gap length", 32'(idle_run), 32'(e.gap));
                    end
                end
                idle_run = 0;
            end else begin
                idle_run++;
            end
        end
    end

    task automatic push_units(input logic [27:0] src, input logic [27:0] dst, input logic [1:0] sz,
                              input int first, input int n, input string tag);
        int step;
        step = 1 << sz;
        for (int k = first; k < first + n; k++) begin
            op_t r, w;
            r.we = 1'b0; r.addr = src + 28'(k * step); r.sz = sz; r.data = '0; r.gap = 0; r.tag = tag;
            w.we = 1'b1; w.addr = dst + 28'(k * step); w.sz = sz;
            w.data = model_rd(r.addr) & mask_of(sz); w.gap = gap_two ? 2 : 1; w.tag = tag;
            expq.push_back(r);
            expq.push_back(w);
        end
    endtask

    task automatic load(input int ch, input logic [27:0] s, input logic [27:0] d,
                        input logic [15:0] n, input logic [1:0] z, input logic b);
        @(negedge clk);
        cfg_we = 4'b0001 << ch; cfg_src = s; cfg_dst = d; cfg_count = n; cfg_size = z; cfg_block = b;
        @(negedge clk);
        cfg_we = '0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_first_write();
        @(negedge clk);
        while (!(bus_valid && bus_we)) @(negedge clk);
    endtask

    task automatic quiet_window(input int ch, input string tag);
        int snap;
        snap = ops;
        dma_req[ch] = 1'b1;
        repeat (20) @(negedge clk);
        dma_req[ch] = 1'b0;
        chk(ops == snap, tag, 32'(ops - snap), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_valid == 1'b0, "R10 bus idle in reset", 32'(bus_valid), 32'd0);
        chk(done == 4'h0 && err == 4'h0, "R10 flags clear in reset", {24'd0, done, err}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R9: single-step words, addresses advance by 4
        gap_two = 1'b0;
        load(2, 28'h0001000, 28'h0002000, 16'd3, 2'd2, 1'b0);
        push_units(28'h0001000, 28'h0002000, 2'd2, 0, 3, "R1");
        dma_req[2] = 1'b1;
        drain();
        chk(done[2] == 1'b1, "R9 done after count", 32'(done), 32'h4);
        dma_req[2] = 1'b0;

        // R2: two-clock gap, unaligned bytes
        gap_two = 1'b1;
        load(1, 28'h0001101, 28'h0002203, 16'd2, 2'd0, 1'b0);
        push_units(28'h0001101, 28'h0002203, 2'd0, 0, 2, "R2");
        dma_req[1] = 1'b1;
        drain();
        dma_req[1] = 1'b0;
        chk(done[1] == 1'b1, "R2 done after byte units", 32'(done), 32'h2);

        // R3: simultaneous requests, lower index first
        gap_two = 1'b0;
        load(3, 28'h0003000, 28'h0004000, 16'd2, 2'd1, 1'b0);
        load(1, 28'h0005000, 28'h0006000, 16'd2, 2'd2, 1'b0);
        push_units(28'h0005000, 28'h0006000, 2'd2, 0, 2, "R3");
        push_units(28'h0003000, 28'h0004000, 2'd1, 0, 2, "R3");
        dma_req = 4'b1010;
        drain();
        dma_req = '0;

        // R5: single-step yields to a higher request raised mid-unit
        load(3, 28'h0007000, 28'h0008000, 16'd3, 2'd2, 1'b0);
        load(0, 28'h0009000, 28'h000A000, 16'd1, 2'd0, 1'b0);
        push_units(28'h0007000, 28'h0008000, 2'd2, 0, 1, "R5");
        push_units(28'h0009000, 28'h000A000, 2'd0, 0, 1, "R5");
        push_units(28'h0007000, 28'h0008000, 2'd2, 1, 2, "R5");
        dma_req[3] = 1'b1;
        wait_first_write();
        dma_req[0] = 1'b1;
        drain();
        dma_req = '0;
        chk(done[0] && done[3], "R5 both channels done", 32'(done), 32'h9);

        // R4: block mode keeps the bus despite a higher request and its own request dropping
        load(2, 28'h000B000, 28'h000C000, 16'd3, 2'd1, 1'b1);
        load(0, 28'h000D000, 28'h000E000, 16'd1, 2'd2, 1'b0);
        push_units(28'h000B000, 28'h000C000, 2'd1, 0, 3, "R4");
        push_units(28'h000D000, 28'h000E000, 2'd2, 0, 1, "R4");
        dma_req[2] = 1'b1;
        wait_first_write();
        dma_req[0] = 1'b1;
        dma_req[2] = 1'b0;
        drain();
        dma_req = '0;
        chk(done[2] == 1'b1, "R4 block channel done", 32'(done), 32'h4);

        // R6: block mode to peripheral page refused
        load(1, 28'h0010000, 28'hFFFF800, 16'd2, 2'd2, 1'b1);
        chk(err[1] == 1'b1, "R6 err on block to peripheral", 32'(err), 32'h2);
        quiet_window(1, "R6 refused channel makes no cycles");

        // R7: size mismatch to a byte-wide peripheral register
        load(1, 28'h0010000, 28'hFFFF000, 16'd1, 2'd2, 1'b0);
        chk(err[1] == 1'b1, "R7 err on size mismatch", 32'(err), 32'h2);
        quiet_window(1, "R7 refused channel makes no cycles");

        // R8: reserved aliased page refused
        load(1, 28'h3FFF010, 28'h0011000, 16'd1, 2'd2, 1'b0);
        chk(err[1] == 1'b1, "R8 err on reserved page", 32'(err), 32'h2);
        quiet_window(1, "R8 refused channel makes no cycles");

        // R9: size code 3 refused
        load(1, 28'h0010000, 28'h0011000, 16'd1, 2'd3, 1'b0);
        chk(err[1] == 1'b1, "R9 err on bad size code", 32'(err), 32'h2);

        // R7: matching halfword to a halfword peripheral register accepted
        load(1, 28'h0012000, 28'hFFFF400, 16'd2, 2'd1, 1'b0);
        chk(err[1] == 1'b0, "R7 matching size accepted", 32'(err), 32'h0);
        push_units(28'h0012000, 28'hFFFF400, 2'd1, 0, 2, "R7");
        dma_req[1] = 1'b1;
        drain();
        dma_req[1] = 1'b0;
        chk(done[1] == 1'b1, "R7 peripheral transfer done", 32'(done), 32'h2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", expq.size(), 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule